// File: doc/BRIEF.md
# Framed Two-Way Stream Splitter

This block sits behind a decimating filter chain whose channels share one time-multiplexed output bus. The bus carries no channel number. Each group of samples, one per channel, forms a packet. The first sample of the group carries a start-of-packet flag and the last carries an end-of-packet flag. The block recovers channel identity from those flags alone. It sends every accepted sample to a dedicated output port, and each port has its own registered data and a one-cycle valid strobe.

Samples usually arrive on about a quarter of the clock cycles. With the upstream chain fully loaded and two channels, each output port fires once every eight cycles. The sources are continuous, so a well-formed stream never leaves a gap inside a packet. The block does not check for gaps: it counts only valid beats, and idle cycles between beats have no effect. When the framing breaks, a sticky error flag is raised and the tracker waits for the next start flag before routing again. The number of channels is a parameter with a default of 2 and a minimum of 2.

Top module: `frame_deinterleaver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all `out_valid` bits are 0, all `out_data` lanes are 0 and `frame_err` is 0.
- R2: A valid beat with `in_sop`=1 and `in_eop`=0 is always routed to port 0 (lane bits DW-1:0), whatever the tracker state.
- R3: After a port-0 beat, the following valid beats go to ports 1, 2, … in order. A beat for a middle port carries neither flag. The beat for port NUM_CH-1 carries `in_eop`=1 and `in_sop`=0, and after it the tracker expects port 0 again.
- R4: At most one `out_valid` bit is high in any cycle. Each pulse lasts exactly one cycle for each accepted beat.
- R5: A port's `out_data` lane changes only in a cycle in which that port's `out_valid` is high, and it holds the last routed sample otherwise.
- R6: Cycles with `in_valid`=0 have no effect, whatever the values of `in_sop`, `in_eop` and `in_data`.
- R7: When port 0 is expected and the tracker is synchronised, a valid beat without `in_sop`, or one with both flags set, sets `frame_err`. The beat is dropped and the tracker enters hunt mode.
- R8: When a later port is expected, a valid beat with `in_sop`=1 and `in_eop`=0 sets `frame_err`, and that beat starts a new packet on port 0.
- R9: When a later port is expected, any other beat whose flags break the R3 pattern sets `frame_err`. Examples are a missing `in_eop` on the last port, or both flags set. The beat is dropped and the tracker hunts.
- R10: The tracker starts in hunt mode after reset. In hunt mode, valid beats without a clean start flag are dropped and do not set `frame_err`.
- R11: Once set, `frame_err` stays 1 until reset.
- R12: An accepted beat appears on its port exactly one clock cycle after it is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat qualifier |
| in_sop | input | 1 | First sample of a channel group |
| in_eop | input | 1 | Last sample of a channel group |
| in_data | input | DW | Input sample |
| out_valid | output | NUM_CH | One-cycle strobe per port |
| out_data | output | NUM_CH*DW | Registered sample per port, port k in bits k*DW+DW-1:k*DW |
| frame_err | output | 1 | Sticky framing error |

## Verification
The bench drives sparse traffic and back-to-back traffic, with junk on the flag and data lines during idle cycles. A design that decoded the flags without checking `in_valid` would produce spurious strobes or corrupt the held lanes.

It also injects every framing fault:
- an end flag where a start is due;
- both flags set on the same beat;
- a start flag in mid-packet;
- a missing end flag.

A tracker that failed to reset its expected port would send later samples to the wrong lane. One that dropped the restarting beat of R8 would lose a port-0 sample.

Leading junk after reset must leave `frame_err` at 0. A reset in the middle of the run must clear the flag, which otherwise stays 1 no matter what traffic follows.

// File: rtl/fdi_pkg.sv
package fdi_pkg;

   typedef enum logic [1:0] {
      VERD_IDLE    = 2'd0,
      VERD_ACCEPT  = 2'd1,
      VERD_RESTART = 2'd2,
      VERD_DROP    = 2'd3
   } verdict_e;

   function automatic int idx_w(input int n);
      return (n > 2) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/fdi_tracker.sv
module fdi_tracker
   import fdi_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int IW     = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   output logic          route_en,
   output logic [IW-1:0] route_idx,
   output logic          err
);

   localparam logic [IW-1:0] LAST = IW'(NUM_CH - 1);
   localparam logic [IW-1:0] ONE  = IW'(1);

   logic [IW-1:0] exp_q, exp_d;
   logic          hunt_q, hunt_d;
   logic          err_q, err_d;
   logic          start_ok, at_last, match;
   verdict_e      verd;

   always_comb begin
      start_ok = in_sop & ~in_eop;
      at_last  = (exp_q == LAST);
      if (hunt_q || exp_q == '0) match = start_ok;
      else                       match = ~in_sop & (in_eop == at_last);

      if (!in_valid)     verd = VERD_IDLE;
      else if (match)    verd = VERD_ACCEPT;
      else if (start_ok) verd = VERD_RESTART;
      else               verd = VERD_DROP;

      exp_d     = exp_q;
      hunt_d    = hunt_q;
      err_d     = err_q;
      route_en  = 1'b0;
      route_idx = exp_q;
      unique case (verd)
         VERD_ACCEPT: begin
            route_en = 1'b1;
            hunt_d   = 1'b0;
            exp_d    = at_last ? '0 : exp_q + ONE;
         end
         VERD_RESTART: begin
            route_en  = 1'b1;
            route_idx = '0;
            hunt_d    = 1'b0;
            exp_d     = ONE;
            err_d     = 1'b1;
         end
         VERD_DROP: begin
            exp_d  = '0;
            hunt_d = 1'b1;
            if (!hunt_q) err_d = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_q  <= '0;
         hunt_q <= 1'b1;
         err_q  <= 1'b0;
      end else begin
         exp_q  <= exp_d;
         hunt_q <= hunt_d;
         err_q  <= err_d;
      end
   end

   assign err = err_q;

   a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   a_r8_midframe_start: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !hunt_q && exp_q != '0 && in_sop && !in_eop) |=> (err_q && exp_q == ONE));

   a_r10_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (hunt_q && !err_q && !(in_valid && in_sop && !in_eop)) |=> !err_q);

   a_r3_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q <= LAST);

endmodule

// File: rtl/fdi_port.sv
module fdi_port #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [DW-1:0] din,
   output logic          valid,
   output logic [DW-1:0] data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         data  <= '0;
      end else begin
         valid <= load;
         if (load) data <= din;
      end
   end

endmodule

// File: rtl/frame_deinterleaver.sv
module frame_deinterleaver
   import fdi_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DW     = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic                 in_sop,
   input  logic                 in_eop,
   input  logic [DW-1:0]        in_data,
   output logic [NUM_CH-1:0]    out_valid,
   output logic [NUM_CH*DW-1:0] out_data,
   output logic                 frame_err
);

   localparam int IW = idx_w(NUM_CH);

   if (NUM_CH < 2) begin : g_bad_ch
      $error("frame_deinterleaver: NUM_CH must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("frame_deinterleaver: DW must be positive");
   end

   logic          route_en;
   logic [IW-1:0] route_idx;

   fdi_tracker #(.NUM_CH(NUM_CH), .IW(IW)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_eop   (in_eop),
      .route_en (route_en),
      .route_idx(route_idx),
      .err      (frame_err)
   );

   for (genvar k = 0; k < NUM_CH; k++) begin : g_port
      logic ld;
      assign ld = route_en && (route_idx == IW'(k));

      fdi_port #(.DW(DW)) u_port (
         .clk  (clk),
         .rst_n(rst_n),
         .load (ld),
         .din  (in_data),
         .valid(out_valid[k]),
         .data (out_data[k*DW +: DW])
      );

      a_r5_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !out_valid[k] |-> $stable(out_data[k*DW +: DW]));
   end

   a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_valid));

   a_r2_start_to_port0: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && !in_eop) |=> (out_valid[0] && out_data[DW-1:0] == $past(in_data)));

   a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (out_valid == '0));

endmodule

// File: tb/test_frame_deinterleaver.sv
module test_frame_deinterleaver;

   localparam int NCH = 2;
   localparam int DW  = 16;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid, in_sop, in_eop;
   logic [DW-1:0]      in_data;
   logic [NCH-1:0]     out_valid;
   logic [NCH*DW-1:0]  out_data;
   logic               frame_err;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit done     = 0;

   // behavioural reference state
   int          m_want;
   bit          m_hunt;
   bit          m_err;
   logic [DW-1:0] m_lane [NCH];
   logic [NCH-1:0] m_vld;

   always #4 clk = ~clk;

   frame_deinterleaver #(.NUM_CH(NCH), .DW(DW)) i_frame_deinterleaver (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
      .out_data(out_data), .frame_err(frame_err)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic compare(input string req);
      check(req, 64'(out_valid), 64'(m_vld), "out_valid");
      check(req, 64'(frame_err), 64'(m_err), "frame_err");
      for (int k = 0; k < NCH; k++)
         check(req, 64'(out_data[k*DW +: DW]), 64'(m_lane[k]), "out_data lane");
   endtask

   task automatic model_reset();
      m_want = 0; m_hunt = 1; m_err = 0; m_vld = '0;
      for (int k = 0; k < NCH; k++) m_lane[k] = '0;
   endtask

   task automatic model_step(input bit v, input bit s, input bit e, input logic [DW-1:0] d);
      bit ok;
      m_vld = '0;
      if (!v) return;
      if (m_want == 0) ok = s && !e;
      else ok = !s && (e == (m_want == NCH - 1));
      if (ok) begin
         m_lane[m_want] = d; m_vld[m_want] = 1'b1;
         m_want = (m_want == NCH - 1) ? 0 : m_want + 1;
         m_hunt = 0;
      end else if (s && !e) begin
         m_err = 1; m_lane[0] = d; m_vld[0] = 1'b1; m_want = 1; m_hunt = 0;
      end else begin
         if (!m_hunt) m_err = 1;
         m_want = 0; m_hunt = 1;
      end
   endtask

   // drive at negedge, then compare at the following negedge
   task automatic beat(input bit v, input bit s, input bit e, input logic [DW-1:0] d, input string req);
      in_valid = v; in_sop = s; in_eop = e; in_data = d;
      model_step(v, s, e, d);
      @(posedge clk);
      @(negedge clk);
      compare(req);
   endtask

   task automatic idle(input int n, input string req);
      for (int i = 0; i < n; i++)
         beat(1'b0, 1'(i), 1'(i + 1), DW'(16'hdead + i), req); // R6 junk on idle lines
   endtask

   task automatic frame(input logic [DW-1:0] a, input logic [DW-1:0] b, input int gap, input string req);
      beat(1'b1, 1'b1, 1'b0, a, req);
      idle(gap, "R6");
      beat(1'b1, 1'b0, 1'b1, b, req);
      idle(gap, "R6");
   endtask

   task automatic do_reset();
      rst_n = 1'b0; in_valid = 0; in_sop = 0; in_eop = 0; in_data = '0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      beat(1'b0, 1'b0, 1'b0, '0, "R1");
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R10: junk while hunting, no error
      beat(1'b1, 1'b0, 1'b1, 16'h1111, "R10");
      beat(1'b1, 1'b0, 1'b0, 16'h2222, "R10");
      beat(1'b1, 1'b1, 1'b1, 16'h3333, "R10");
      // R2 R3 R12: sparse traffic, one beat in four
      for (int i = 0; i < 6; i++)
         frame(DW'(16'h0100 + i), DW'(16'h0200 + i), 3, "R3");
      // R4 R12: back-to-back
      for (int i = 0; i < 5; i++)
         frame(DW'(16'h0a00 + i), DW'(16'h0b00 + i), 0, "R12");
      idle(4, "R5");
      // R7: end flag where start is due
      beat(1'b1, 1'b0, 1'b1, 16'h7001, "R7");
      beat(1'b1, 1'b0, 1'b1, 16'h7002, "R7");
      frame(16'h7100, 16'h7200, 1, "R2");
      // R7: both flags on a start beat
      beat(1'b1, 1'b1, 1'b1, 16'h7300, "R7");
      frame(16'h7400, 16'h7500, 0, "R11");
      // R8: start in mid-packet restarts on port 0
      beat(1'b1, 1'b1, 1'b0, 16'h8001, "R8");
      beat(1'b1, 1'b1, 1'b0, 16'h8002, "R8");
      beat(1'b1, 1'b0, 1'b1, 16'h8003, "R8");
      // R9: missing end flag, then both flags on last port
      beat(1'b1, 1'b1, 1'b0, 16'h9001, "R9");
      beat(1'b1, 1'b0, 1'b0, 16'h9002, "R9");
      beat(1'b1, 1'b0, 1'b1, 16'h9003, "R9");
      beat(1'b1, 1'b1, 1'b0, 16'h9004, "R9");
      beat(1'b1, 1'b1, 1'b1, 16'h9005, "R9");
      frame(16'h9100, 16'h9200, 2, "R11");
      // R1: reset clears the sticky flag
      do_reset();
      beat(1'b1, 1'b0, 1'b1, 16'hc001, "R10");
      frame(16'hc100, 16'hc200, 1, "R3");
      beat(1'b1, 1'b0, 1'b1, 16'hc300, "R7");
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      while (!done && cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule